// File: doc/BRIEF.md
# I2C Register Target with Two-Byte Addressing

This block is a target on a two-wire I2C bus. It runs from a fast system clock and gives a bus controller access to a 64K-byte internal register space. It samples SCL and SDA through two-flop synchronizers and spike filters, then finds start, repeated start and stop conditions and frames the bytes. It answers only to its own 7-bit device address, which strap inputs pick from a set of seven. It never drives SCL, and it pulls SDA low only through an open-drain enable.

A write transfer carries two register address bytes, high byte first, then any number of data bytes. Each data byte becomes a one-cycle write strobe, and a 16-bit pointer steps after it. A write that carries only the address bytes just sets the pointer. A repeated start with the read bit set then streams bytes from that pointer. Each byte is fetched with a one-cycle read request, and the register side returns the data in the cycle after the request.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_re` are low and `reg_addr` is 0x0000.
- R2: The device address is `DEV_BASE + addr_sel` for strap values 0 to 6, and strap value 7 acts as 6. The first byte after a start carries the address in bits 7:1 and the direction in bit 0 (1 = read). On a match, the block pulls SDA low during the ninth clock of that byte.
- R3: On an address mismatch, the block does not acknowledge. It then drives no SDA and issues no write or read strobe until the next start or stop.
- R4: Each data byte in a write transfer is acknowledged and gives one single-cycle `reg_we` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the current pointer.
- R5: In a write transfer, the two bytes after the device address load the pointer, high byte first, and each is acknowledged. The pointer steps by one after each data byte written.
- R6: The pointer wraps from 0xFFFF to 0x0000.
- R7: In a read transfer, each byte is requested with a single-cycle `reg_re` at the current pointer. The block samples `reg_rdata` in the cycle after `reg_re` and shifts the byte out MSB first. A write transfer that carries only the address bytes, followed by a repeated start with the read bit set, returns data from the loaded pointer.
- R8: The pointer steps by one after every byte read, including a byte the controller did not acknowledge. A later read with no address bytes continues from there.
- R9: The block changes `sda_oe` only while the filtered SCL is low, except that it releases SDA at a start or stop. A controller not-acknowledge ends the read: SDA stays released until the next start or stop.
- R10: A start or stop at any bit position resets the byte framing. After a start, the next eight bits are a device address. After a stop, the block is idle, and a partial byte is discarded.
- R11: Pulses shorter than 50 ns on SCL or SDA have no effect. The filter length is `FILT_LEN` system clocks, 4 at 50 MHz.
- R12: Transfers work at both 100 kHz and 400 kHz bus rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 3 | Strap that picks the device address |
| reg_addr | output | 16 | Register pointer used by writes and reads |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read request |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |

## Verification
The bench sweeps every strap value against eight candidate addresses. A wrong address map would acknowledge the wrong candidate, or none, for some strap value. It sends starts and stops in the middle of a byte. A design that kept the stale bit count would then take a data bit as the device address or write a truncated byte. It reads past a controller not-acknowledge and then reads again with no address bytes. A design that kept driving after the not-acknowledge would corrupt the released bus, and a pointer that did not step on the last byte would repeat data. It writes across 0xFFFF and injects 45 ns spikes on both lines inside a byte. A pointer without wrap-around, or a filter that is too short, would produce wrong strobes or a spurious start.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] DEV_BASE = 7'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_sel,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [7:0]  reg_rdata
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_DEV  = 3'd1;
  localparam logic [2:0] ST_AH   = 3'd2;
  localparam logic [2:0] ST_AL   = 3'd3;
  localparam logic [2:0] ST_WR   = 3'd4;
  localparam logic [2:0] ST_RD   = 3'd5;
  localparam logic [2:0] ST_IGN  = 3'd6;

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic s1, s2, f;
    logic [CW-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        f  <= 1'b1;
        c  <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 == f) c <= '0;
        else if (c == CNT_TOP) begin
          f <= s2;
          c <= '0;
        end else c <= c + 1'b1;
      end
    end
    assign filt[g] = f;
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  logic [2:0] sel_eff;
  logic [6:0] my_addr;
  assign sel_eff = (addr_sel == 3'd7) ? 3'd6 : addr_sel;
  assign my_addr = DEV_BASE + {4'd0, sel_eff};

  logic [2:0]  st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, txsh, rbuf, wdata_q;
  logic [15:0] ptr;
  logic        rw, mnack, fetch, re_d, we_q, oe;

  wire dev_hit = (shreg[7:1] == my_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      rbuf    <= '0;
      wdata_q <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      mnack   <= 1'b0;
      fetch   <= 1'b0;
      re_d    <= 1'b0;
      we_q    <= 1'b0;
      oe      <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      fetch <= 1'b0;
      re_d  <= fetch;
      if (re_d) rbuf <= reg_rdata;

      if (start_det) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (st != ST_IDLE && st != ST_IGN) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_f};
            if (st == ST_RD) txsh <= {txsh[6:0], 1'b0};
          end else if (st == ST_RD) begin
            mnack <= sda_f;
            ptr   <= ptr + 16'd1;
            fetch <= ~sda_f;
          end
          if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt < 4'd8) begin
            if (st == ST_RD) oe <= ~txsh[7];
          end else if (bitcnt == 4'd8) begin
            case (st)
              ST_DEV: begin
                if (dev_hit) begin
                  oe    <= 1'b1;
                  rw    <= shreg[0];
                  fetch <= shreg[0];
                end else st <= ST_IGN;
              end
              ST_AH: begin
                oe        <= 1'b1;
                ptr[15:8] <= shreg;
              end
              ST_AL: begin
                oe       <= 1'b1;
                ptr[7:0] <= shreg;
              end
              ST_WR: begin
                oe      <= 1'b1;
                we_q    <= 1'b1;
                wdata_q <= shreg;
              end
              default: oe <= 1'b0;
            endcase
          end else begin
            bitcnt <= '0;
            oe     <= 1'b0;
            case (st)
              ST_DEV: begin
                if (rw) begin
                  st   <= ST_RD;
                  txsh <= rbuf;
                  oe   <= ~rbuf[7];
                end else st <= ST_AH;
              end
              ST_AH: st <= ST_AL;
              ST_AL: st <= ST_WR;
              ST_WR: ptr <= ptr + 16'd1;
              ST_RD: begin
                if (mnack) st <= ST_IGN;
                else begin
                  txsh <= rbuf;
                  oe   <= ~rbuf[7];
                end
              end
              default: st <= ST_IGN;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe    = oe;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = fetch;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_det,
  input logic stop_det,
  input logic ign,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_release_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_f || $past(start_det) || $past(stop_det)));

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || start_det) |=> !sda_oe);

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_re_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> (!sda_oe && !reg_we && !reg_re));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .start_det (start_det),
  .stop_det  (stop_det),
  .ign       (st == ST_IGN),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_re    (reg_re)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam logic [6:0] BASE = 7'h38;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0, sda_g = 1'b0;
  logic [2:0]  addr_sel = 3'd0;
  logic [7:0]  rdata_r = 8'h00;
  wire         sda_oe, reg_we, reg_re;
  wire  [15:0] reg_addr;
  wire  [7:0]  reg_wdata;
  wire         scl_line = scl_m ^ scl_g;
  wire         sda_bus  = (sda_m ^ sda_g) & ~sda_oe;

  i2c_reg_target #(.FILT_LEN(4), .DEV_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_bus),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(rdata_r)
  );

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hC3;
  endfunction

  always @(posedge clk) if (reg_re) rdata_r <= exp_rd(reg_addr);

  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  int          wn = 0;
  always @(posedge clk) if (reg_we) begin
    wa[wn % 64] <= reg_addr;
    wd[wn % 64] <= reg_wdata;
    wn <= wn + 1;
  end

  int  total = 0, bad = 0, q = 31;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(q);
    scl_m = 1'b1; wt(q);
    sda_m = 1'b0; wt(q);
    scl_m = 1'b0; wt(q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(q);
    scl_m = 1'b1; wt(q);
    sda_m = 1'b1; wt(q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        #5 scl_g = 1'b1; #45 scl_g = 1'b0;
      end
      wt(q);
      scl_m = 1'b1; wt(q);
      if (glitch && i == 5) begin
        #3 sda_g = 1'b1; #45 sda_g = 1'b0;
      end
      wt(q);
      scl_m = 1'b0; wt(q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, input bit glitch);
    send_bits(b, 8, glitch);
    sda_m = 1'b1; wt(q);
    scl_m = 1'b1; wt(q);
    ack = ~sda_bus;
    wt(q);
    scl_m = 1'b0; wt(q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(q);
      scl_m = 1'b1; wt(q);
      b[i] = sda_bus;
      wt(q);
      scl_m = 1'b0;
    end
    wt(q);
    sda_m = ~ack; wt(q);
    scl_m = 1'b1; wt(2 * q);
    scl_m = 1'b0; wt(q);
    sda_m = 1'b1;
  endtask

  task automatic write_xfer(input logic [15:0] a, input logic [7:0] d0, input int n,
                            input bit glitch, input string req);
    bit ack;
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0); chk(ack, req, ack, 1);
    send_byte(a[15:8], ack, 1'b0);             chk(ack, "R5 addr hi ack", ack, 1);
    send_byte(a[7:0], ack, 1'b0);              chk(ack, "R5 addr lo ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i * 17), ack, glitch);
      chk(ack, "R4 data ack", ack, 1);
    end
    i2c_stop();
  endtask

  initial begin
    int      base_n;
    bit      ack;
    logic [7:0] b;
    wt(5);
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R1 reset outputs",
        {sda_oe, reg_we, reg_re}, 0);
    chk(reg_addr == 16'h0000, "R1 reset pointer", reg_addr, 0);
    rst_n = 1'b1;
    wt(20);

    // R2: every strap against eight candidates, faster bus
    q = 20;
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        addr_sel = 3'(s);
        i2c_start();
        send_byte({BASE + 7'(c), 1'b0}, ack, 1'b0);
        i2c_stop();
        chk(ack == (c == ((s == 7) ? 6 : s)), "R2 address sweep", ack,
            (c == ((s == 7) ? 6 : s)));
      end
    end
    q = 31;
    addr_sel = 3'd1;

    // R3: mismatch, then bytes that would otherwise be written
    base_n = wn;
    i2c_start();
    send_byte({BASE + 7'd5, 1'b0}, ack, 1'b0); chk(!ack, "R3 mismatch nack", ack, 0);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'h10 + 8'(i), ack, 1'b0);
      chk(!ack, "R3 ignored byte", ack, 0);
    end
    i2c_stop();
    chk(wn == base_n, "R3 no write", wn - base_n, 0);

    // R4 R5: three data bytes
    base_n = wn;
    write_xfer(16'h1234, 8'h5A, 3, 1'b0, "R2 ack write");
    wt(4);
    chk(wn - base_n == 3, "R4 write count", wn - base_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wa[(base_n + i) % 64] == 16'h1234 + 16'(i), "R5 write address",
          wa[(base_n + i) % 64], 16'h1234 + i);
      chk(wd[(base_n + i) % 64] == 8'h5A + 8'(i * 17), "R4 write data",
          wd[(base_n + i) % 64], 8'h5A + 8'(i * 17));
    end

    // R6: wrap at the top of the space
    base_n = wn;
    write_xfer(16'hFFFF, 8'h81, 2, 1'b0, "R2 ack write");
    wt(4);
    chk(wa[base_n % 64] == 16'hFFFF, "R6 before wrap", wa[base_n % 64], 16'hFFFF);
    chk(wa[(base_n + 1) % 64] == 16'h0000, "R6 after wrap", wa[(base_n + 1) % 64], 0);

    // R7 R8 R9: pointer load, repeated start, read four, last nacked
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0); chk(ack, "R7 dev ack", ack, 1);
    send_byte(8'h7F, ack, 1'b0);
    send_byte(8'hFE, ack, 1'b0);
    i2c_start();
    send_byte({BASE + 7'd1, 1'b1}, ack, 1'b0); chk(ack, "R7 read dev ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, i < 3);
      chk(b == exp_rd(16'h7FFE + 16'(i)), "R7 read data", b, exp_rd(16'h7FFE + 16'(i)));
    end
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
    i2c_stop();
    i2c_start();
    send_byte({BASE + 7'd1, 1'b1}, ack, 1'b0);
    recv_byte(b, 1'b0);
    i2c_stop();
    chk(b == exp_rd(16'h8002), "R8 pointer continues", b, exp_rd(16'h8002));

    // R10: stop mid-byte, then start mid-byte
    base_n = wn;
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0);
    send_bits(8'h12, 4, 1'b0);
    i2c_stop();
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0);
    send_byte(8'h00, ack, 1'b0);
    send_bits(8'hC4, 3, 1'b0);
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0); chk(ack, "R10 restart framing", ack, 1);
    send_byte(8'h00, ack, 1'b0);
    send_byte(8'h40, ack, 1'b0);
    send_byte(8'h3C, ack, 1'b0);
    i2c_stop();
    wt(4);
    chk(wn - base_n == 1, "R10 single write", wn - base_n, 1);
    chk(wa[base_n % 64] == 16'h0040 && wd[base_n % 64] == 8'h3C, "R10 write target",
        {wa[base_n % 64], wd[base_n % 64]}, 24'h00403C);

    // R11: 45 ns spikes on SCL (low phase) and SDA (high phase) inside a data byte
    base_n = wn;
    write_xfer(16'h2468, 8'hA5, 1, 1'b1, "R11 dev ack");
    wt(4);
    chk(wn - base_n == 1, "R11 write count", wn - base_n, 1);
    chk(wa[base_n % 64] == 16'h2468 && wd[base_n % 64] == 8'hA5, "R11 glitch immune",
        {wa[base_n % 64], wd[base_n % 64]}, 24'h2468A5);

    // R12: standard-mode rate
    q = 125;
    base_n = wn;
    i2c_start();
    send_byte({BASE + 7'd1, 1'b0}, ack, 1'b0); chk(ack, "R12 dev ack", ack, 1);
    send_byte(8'h0B, ack, 1'b0);
    send_byte(8'hCD, ack, 1'b0);
    send_byte(8'h77, ack, 1'b0);
    i2c_start();
    send_byte({BASE + 7'd1, 1'b1}, ack, 1'b0);
    recv_byte(b, 1'b0);
    i2c_stop();
    chk(wa[base_n % 64] == 16'h0BCD && wd[base_n % 64] == 8'h77, "R12 slow write",
        {wa[base_n % 64], wd[base_n % 64]}, 24'h0BCD77);
    chk(b == exp_rd(16'h0BCE), "R12 slow read", b, exp_rd(16'h0BCE));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule